// File: doc/BRIEF.md
# Cache Line Maintenance Sequencer

This block carries one cache-maintenance command for a single line of a shared cache through to completion. The cache sits below inclusive upper-level clients and above a coherent interconnect. A requester hands over a command and a line address. The block then reads the directory for that line. From the reported hit, dirty and client-presence bits it decides which steps the command needs.

It then runs those steps over separate request/acknowledge handshakes:
- probe the upper clients;
- write dirty data back;
- send the maintenance request to the interconnect;
- clear the directory entry;
- acknowledge upward with the line address.

A probe answer that carries dirty data adds a writeback part-way through. For clean and flush, the downstream request waits until every probe answer and any writeback acknowledge have come back.

Only one command is handled at a time. The request port reports not-ready from the moment a command is accepted until its upward acknowledge has completed.

Top module: `cmo_seq`

## Requirements
- R1: After reset the block is idle: `req_ready` is 1 and `lkp_valid`, `prb_valid`, `wb_valid`, `dn_valid`, `dw_valid` and `ack_valid` are all 0.
- R2: Once a command is accepted, `req_ready` stays 0 until the upward acknowledge handshake completes. In the cycle after that handshake, `req_ready` is 1 again.
- R3: A command code of 3 or higher is a no-op. The codes are 0 clean, 1 flush, 2 invalidate, 3 zero, and 4 to 7 reserved. A no-op is acknowledged with no lookup, probe, writeback, downstream or directory handshake.
- R4: A probe is sent for clean, flush and invalidate only when the lookup reports a hit with at least one client present.
- R5: A writeback is planned at lookup for clean or flush on a dirty hit. Invalidate never writes back.
- R6: For clean or flush, a probe answer with `prb_ack_dirty` set adds a writeback, and its acknowledge is awaited, even if none was planned at lookup.
- R7: A writeback is not offered until the last probe answer (`prb_ack_last`) has been received.
- R8: For clean and flush, the downstream request is not offered until the last probe answer and any writeback acknowledge have both been received.
- R9: Every maintenance command sends exactly one downstream request. `dn_kind` is 0 (clean-shared) for clean, 1 (clean-invalid) for flush and 2 (make-invalid) for invalidate. `dn_addr` is the line address with offset bits cleared. `dn_exp_ack` is 0.
- R10: A directory clear (`dw_valid`) is issued for invalidate on a hit, and for clean or flush whenever a writeback is performed. Otherwise none is issued.
- R11: `ack_valid` rises only after the downstream completion and the last probe answer have both been received. `ack_addr` carries the line address with offset bits cleared.
- R12: While an output handshake is stalled by a low ready, its valid stays high and its payload does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Command offered |
| req_ready | output | 1 | Block idle, command can be taken |
| req_op | input | 3 | Command code (0 clean, 1 flush, 2 invalidate, 3+ no-op) |
| req_addr | input | ADDR_W | Byte address inside the target line |
| lkp_valid | output | 1 | Directory lookup request |
| lkp_ready | input | 1 | Lookup accepted; result valid in same cycle |
| lkp_addr | output | ADDR_W | Line address for lookup |
| lkp_hit | input | 1 | Line present in directory |
| lkp_dirty | input | 1 | Line dirty |
| lkp_clients | input | 1 | At least one upper client holds the line |
| prb_valid | output | 1 | Probe request to upper clients |
| prb_ready | input | 1 | Probe request accepted |
| prb_addr | output | ADDR_W | Probed line address |
| prb_ack_valid | input | 1 | Probe answer received |
| prb_ack_last | input | 1 | This answer is the last one |
| prb_ack_dirty | input | 1 | This answer returned dirty data |
| wb_valid | output | 1 | Writeback request |
| wb_ready | input | 1 | Writeback accepted |
| wb_addr | output | ADDR_W | Written-back line address |
| wb_ack_valid | input | 1 | Writeback acknowledged |
| dn_valid | output | 1 | Downstream maintenance request |
| dn_ready | input | 1 | Downstream request accepted |
| dn_kind | output | 2 | 0 clean-shared, 1 clean-invalid, 2 make-invalid |
| dn_addr | output | ADDR_W | Downstream target line address |
| dn_exp_ack | output | 1 | Completion-acknowledge expected (always 0) |
| dn_comp_valid | input | 1 | Downstream completion received |
| dw_valid | output | 1 | Directory entry clear request |
| dw_ready | input | 1 | Directory clear accepted |
| dw_addr | output | ADDR_W | Line whose entry is cleared |
| ack_valid | output | 1 | Upward completion acknowledge |
| ack_ready | input | 1 | Acknowledge taken |
| ack_addr | output | ADDR_W | Line address of the completed command |

## Verification
A wrong pending-step flag shows directly at the ports. A lost wait flag lets `wb_valid` or `dn_valid` rise in the cycle right after a probe or writeback request, before its answer has come back. A stuck flag holds the block in the running state, so `ack_valid` never arrives and `req_ready` stays low. A mis-decoded lookup shows up as a missing or extra probe, writeback or directory clear within a few cycles of the lookup handshake. A late-writeback fault shows up as a writeback missing after a dirty probe answer. The directed scenarios record the cycle of every handshake and compare the ordering and payloads against these rules.

// File: rtl/cmo_pkg.sv
package cmo_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LKP  = 2'd1,
    ST_RUN  = 2'd2,
    ST_ACK  = 2'd3
  } cmo_state_e;

  localparam logic [2:0] OP_CLEAN = 3'd0;
  localparam logic [2:0] OP_FLUSH = 3'd1;
  localparam logic [2:0] OP_INVAL = 3'd2;

  localparam logic [1:0] DN_CLEAN_SHARED  = 2'd0;
  localparam logic [1:0] DN_CLEAN_INVALID = 2'd1;
  localparam logic [1:0] DN_MAKE_INVALID  = 2'd2;

  localparam int NSTEP    = 4;
  localparam int STEP_PRB = 0;
  localparam int STEP_WB  = 1;
  localparam int STEP_DN  = 2;
  localparam int STEP_DW  = 3;

endpackage

// File: rtl/cmo_op_decode.sv
module cmo_op_decode
  import cmo_pkg::*;
(
  input  logic [2:0] op,
  output logic       is_cf,
  output logic       is_inval,
  output logic       is_maint,
  output logic [1:0] dn_kind
);
  always_comb begin
    is_cf    = (op == OP_CLEAN) || (op == OP_FLUSH);
    is_inval = (op == OP_INVAL);
    is_maint = is_cf || is_inval;
    unique case (op)
      OP_CLEAN: dn_kind = DN_CLEAN_SHARED;
      OP_FLUSH: dn_kind = DN_CLEAN_INVALID;
      default:  dn_kind = DN_MAKE_INVALID;
    endcase
  end
endmodule

// File: rtl/cmo_step_plan.sv
module cmo_step_plan
  import cmo_pkg::*;
(
  input  logic             is_cf,
  input  logic             is_inval,
  input  logic             lkp_fire,
  input  logic             hit,
  input  logic             dirty,
  input  logic             clients,
  input  logic             late_dirty,
  output logic [NSTEP-1:0] arm_send,
  output logic [NSTEP-1:0] arm_wait
);
  logic maint;
  logic need_prb;
  logic need_wb;
  logic need_dw;

  always_comb begin
    maint    = is_cf || is_inval;
    need_prb = lkp_fire && maint && hit && clients;
    need_wb  = (lkp_fire && is_cf && hit && dirty) || (late_dirty && is_cf);
    need_dw  = (lkp_fire && is_inval && hit) || need_wb;

    arm_send           = '0;
    arm_wait           = '0;
    arm_send[STEP_PRB] = need_prb;
    arm_wait[STEP_PRB] = need_prb;
    arm_send[STEP_WB]  = need_wb;
    arm_wait[STEP_WB]  = need_wb;
    arm_send[STEP_DN]  = lkp_fire && maint;
    arm_wait[STEP_DN]  = lkp_fire && maint;
    arm_send[STEP_DW]  = need_dw;
  end
endmodule

// File: rtl/cmo_step_slot.sv
module cmo_step_slot (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic arm_send,
  input  logic arm_wait,
  input  logic send_fire,
  input  logic resp,
  output logic send_pend,
  output logic wait_pend
);
  logic send_d;
  logic wait_d;

  always_comb begin
    send_d = send_pend;
    wait_d = wait_pend;
    if (clr) begin
      send_d = 1'b0;
      wait_d = 1'b0;
    end else begin
      if (arm_send)       send_d = 1'b1;
      else if (send_fire) send_d = 1'b0;
      if (arm_wait)       wait_d = 1'b1;
      else if (resp)      wait_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      send_pend <= 1'b0;
      wait_pend <= 1'b0;
    end else begin
      send_pend <= send_d;
      wait_pend <= wait_d;
    end
  end
endmodule

// File: rtl/cmo_seq.sv
module cmo_seq
  import cmo_pkg::*;
#(
  parameter int ADDR_W   = 48,
  parameter int LINE_OFF = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              lkp_valid,
  input  logic              lkp_ready,
  output logic [ADDR_W-1:0] lkp_addr,
  input  logic              lkp_hit,
  input  logic              lkp_dirty,
  input  logic              lkp_clients,
  output logic              prb_valid,
  input  logic              prb_ready,
  output logic [ADDR_W-1:0] prb_addr,
  input  logic              prb_ack_valid,
  input  logic              prb_ack_last,
  input  logic              prb_ack_dirty,
  output logic              wb_valid,
  input  logic              wb_ready,
  output logic [ADDR_W-1:0] wb_addr,
  input  logic              wb_ack_valid,
  output logic              dn_valid,
  input  logic              dn_ready,
  output logic [1:0]        dn_kind,
  output logic [ADDR_W-1:0] dn_addr,
  output logic              dn_exp_ack,
  input  logic              dn_comp_valid,
  output logic              dw_valid,
  input  logic              dw_ready,
  output logic [ADDR_W-1:0] dw_addr,
  output logic              ack_valid,
  input  logic              ack_ready,
  output logic [ADDR_W-1:0] ack_addr
);
  localparam int TAG_W = ADDR_W - LINE_OFF;

  cmo_state_e       state_q, state_d;
  logic [2:0]       op_q;
  logic [TAG_W-1:0] line_q;
  logic [ADDR_W-1:0] line_addr;
  logic             unused_low;

  logic req_fire, lkp_fire, run;
  logic is_cf, is_inval, is_maint;
  logic req_maint, late_dirty, cf_gate, all_clear;
  logic [NSTEP-1:0] arm_send, arm_wait, send_fire, resp, send_pend, wait_pend;

  assign unused_low = ^req_addr[LINE_OFF-1:0];
  assign line_addr  = {line_q, {LINE_OFF{1'b0}}};

  cmo_op_decode u_dec (
    .op       (op_q),
    .is_cf    (is_cf),
    .is_inval (is_inval),
    .is_maint (is_maint),
    .dn_kind  (dn_kind)
  );

  assign req_ready = (state_q == ST_IDLE);
  assign req_fire  = req_valid && req_ready;
  assign req_maint = (req_op <= OP_INVAL);
  assign lkp_valid = (state_q == ST_LKP);
  assign lkp_fire  = lkp_valid && lkp_ready;
  assign run       = (state_q == ST_RUN);

  assign late_dirty = run && prb_ack_valid && prb_ack_dirty && wait_pend[STEP_PRB];

  cmo_step_plan u_plan (
    .is_cf      (is_cf),
    .is_inval   (is_inval),
    .lkp_fire   (lkp_fire),
    .hit        (lkp_hit),
    .dirty      (lkp_dirty),
    .clients    (lkp_clients),
    .late_dirty (late_dirty),
    .arm_send   (arm_send),
    .arm_wait   (arm_wait)
  );

  // Response for each step clears its wait flag; the directory clear has no response.
  assign resp[STEP_PRB] = prb_ack_valid && prb_ack_last;
  assign resp[STEP_WB]  = wb_ack_valid;
  assign resp[STEP_DN]  = dn_comp_valid;
  assign resp[STEP_DW]  = 1'b0;

  assign send_fire[STEP_PRB] = prb_valid && prb_ready;
  assign send_fire[STEP_WB]  = wb_valid && wb_ready;
  assign send_fire[STEP_DN]  = dn_valid && dn_ready;
  assign send_fire[STEP_DW]  = dw_valid && dw_ready;

  for (genvar g = 0; g < NSTEP; g++) begin : g_step
    cmo_step_slot u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (req_fire),
      .arm_send  (arm_send[g]),
      .arm_wait  (arm_wait[g]),
      .send_fire (send_fire[g]),
      .resp      (resp[g]),
      .send_pend (send_pend[g]),
      .wait_pend (wait_pend[g])
    );
  end

  // Clean/flush ordering: probes finished, writeback acknowledged.
  assign cf_gate = !send_pend[STEP_PRB] && !wait_pend[STEP_PRB] &&
                   !send_pend[STEP_WB]  && !wait_pend[STEP_WB];

  assign prb_valid  = run && send_pend[STEP_PRB];
  assign wb_valid   = run && send_pend[STEP_WB] && !send_pend[STEP_PRB] && !wait_pend[STEP_PRB];
  assign dn_valid   = run && send_pend[STEP_DN] && (is_inval || cf_gate);
  assign dw_valid   = run && send_pend[STEP_DW] && cf_gate;
  assign dn_exp_ack = 1'b0;
  assign ack_valid  = (state_q == ST_ACK);

  assign lkp_addr = line_addr;
  assign prb_addr = line_addr;
  assign wb_addr  = line_addr;
  assign dn_addr  = line_addr;
  assign dw_addr  = line_addr;
  assign ack_addr = line_addr;

  assign all_clear = !(|send_pend) && !(|wait_pend);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (req_fire)  state_d = req_maint ? ST_LKP : ST_ACK;
      ST_LKP:  if (lkp_fire)  state_d = ST_RUN;
      ST_RUN:  if (all_clear) state_d = ST_ACK;
      ST_ACK:  if (ack_ready) state_d = ST_IDLE;
      default:                state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= '0;
      line_q <= '0;
    end else if (req_fire) begin
      op_q   <= req_op;
      line_q <= req_addr[ADDR_W-1:LINE_OFF];
    end
  end

  // ---------------- assertions ----------------
  assert_busy_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire |=> !req_ready);

  assert_noop_no_lookup_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_fire && !req_maint) |=> ack_valid && !lkp_valid);

  assert_wb_after_probes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> !prb_valid);

  assert_dn_after_wb_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_valid && is_cf) |-> !wb_valid && !prb_valid);

  assert_ack_alone_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |-> !(prb_valid || wb_valid || dn_valid || dw_valid || lkp_valid));

  assert_ack_not_early_R11: assert property (@(posedge clk) disable iff (!rst_n)
    lkp_fire |=> !ack_valid);

  assert_dn_stable_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_valid && !dn_ready) |=> dn_valid && $stable(dn_addr) && $stable(dn_kind));

  assert_wb_stable_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && !wb_ready) |=> wb_valid && $stable(wb_addr));

  assert_ack_stable_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && !ack_ready) |=> ack_valid && $stable(ack_addr));

endmodule

// File: tb/cmo_seq_test.sv
module cmo_seq_test;
  localparam int AW = 48;
  localparam int OFF = 6;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_ready;
  logic [2:0] req_op;
  logic [AW-1:0] req_addr;
  logic lkp_valid, lkp_ready, lkp_hit, lkp_dirty, lkp_clients;
  logic [AW-1:0] lkp_addr;
  logic prb_valid, prb_ready, prb_ack_valid, prb_ack_last, prb_ack_dirty;
  logic [AW-1:0] prb_addr;
  logic wb_valid, wb_ready, wb_ack_valid;
  logic [AW-1:0] wb_addr;
  logic dn_valid, dn_ready, dn_exp_ack, dn_comp_valid;
  logic [1:0] dn_kind;
  logic [AW-1:0] dn_addr;
  logic dw_valid, dw_ready;
  logic [AW-1:0] dw_addr;
  logic ack_valid, ack_ready;
  logic [AW-1:0] ack_addr;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  cmo_seq #(.ADDR_W(AW), .LINE_OFF(OFF)) uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op), .req_addr(req_addr),
    .lkp_valid(lkp_valid), .lkp_ready(lkp_ready), .lkp_addr(lkp_addr),
    .lkp_hit(lkp_hit), .lkp_dirty(lkp_dirty), .lkp_clients(lkp_clients),
    .prb_valid(prb_valid), .prb_ready(prb_ready), .prb_addr(prb_addr),
    .prb_ack_valid(prb_ack_valid), .prb_ack_last(prb_ack_last), .prb_ack_dirty(prb_ack_dirty),
    .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_addr(wb_addr), .wb_ack_valid(wb_ack_valid),
    .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_kind(dn_kind), .dn_addr(dn_addr),
    .dn_exp_ack(dn_exp_ack), .dn_comp_valid(dn_comp_valid),
    .dw_valid(dw_valid), .dw_ready(dw_ready), .dw_addr(dw_addr),
    .ack_valid(ack_valid), .ack_ready(ack_ready), .ack_addr(ack_addr)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #1500000;
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end

  task automatic run_op(input logic [2:0] op, input logic [AW-1:0] addr,
                        input bit hit, input bit dirty, input bit clients,
                        input int nprb, input int dirty_idx, input int dn_stall);
    bit maint, cf, inval, exp_prb, exp_wb, exp_dw, done, dn_seen;
    logic [AW-1:0] line, dn_addr_s;
    logic [1:0] dn_kind_s;
    int t_prb, t_pack, t_wb, t_wback, t_dn, t_comp, t_dw, t_ack;
    int n_lkp, n_prb, n_wb, n_dn, n_dw, busy_bad, stall_left, stall_bad;
    int pack_left, pack_i, wb_cnt, dn_cnt;
    logic [AW-1:0] ack_addr_s;
    maint = (op <= 3'd2);
    cf    = (op <= 3'd1);
    inval = (op == 3'd2);
    line  = {addr[AW-1:OFF], {OFF{1'b0}}};
    exp_prb = maint && hit && clients;
    exp_wb  = cf && ((hit && dirty) || (exp_prb && dirty_idx >= 0 && dirty_idx < nprb));
    exp_dw  = (inval && hit) || exp_wb;
    t_prb = -1; t_pack = -1; t_wb = -1; t_wback = -1; t_dn = -1; t_comp = -1; t_dw = -1; t_ack = -1;
    n_lkp = 0; n_prb = 0; n_wb = 0; n_dn = 0; n_dw = 0; busy_bad = 0; stall_bad = 0;
    pack_left = 0; pack_i = 0; wb_cnt = 0; dn_cnt = 0; stall_left = dn_stall;
    done = 0; dn_seen = 0; dn_addr_s = '0; dn_kind_s = '0; ack_addr_s = '0;

    @(negedge clk);
    chk(req_ready == 1'b1, "R2", "idle before request", req_ready, 1);
    req_valid = 1; req_op = op; req_addr = addr;
    lkp_hit = hit; lkp_dirty = dirty; lkp_clients = clients;
    @(negedge clk);
    req_valid = 0;
    for (int cyc = 0; cyc < 300 && !done; cyc++) begin
      prb_ack_valid = 0; prb_ack_last = 0; prb_ack_dirty = 0;
      wb_ack_valid = 0; dn_comp_valid = 0; dn_ready = 1;
      if (pack_left > 0) begin
        prb_ack_valid = 1;
        prb_ack_last  = (pack_left == 1);
        prb_ack_dirty = (pack_i == dirty_idx);
        if (pack_left == 1) t_pack = cyc;
        pack_left--; pack_i++;
      end
      if (wb_cnt > 0) begin
        wb_cnt--;
        if (wb_cnt == 0) begin wb_ack_valid = 1; t_wback = cyc; end
      end
      if (dn_cnt > 0) begin
        dn_cnt--;
        if (dn_cnt == 0) begin dn_comp_valid = 1; t_comp = cyc; end
      end
      if (req_ready) busy_bad++;
      if (lkp_valid) n_lkp++;
      if (prb_valid) begin
        n_prb++; if (t_prb < 0) t_prb = cyc;
        pack_left = nprb; pack_i = 0;
      end
      if (wb_valid) begin
        n_wb++; t_wb = cyc; wb_cnt = 2;
      end
      if (dn_valid) begin
        if (!dn_seen) begin dn_seen = 1; dn_addr_s = dn_addr; dn_kind_s = dn_kind; end
        if (dn_addr != dn_addr_s || dn_kind != dn_kind_s) stall_bad++;
        if (stall_left > 0) begin
          dn_ready = 0; stall_left--;
        end else begin
          n_dn++; t_dn = cyc; dn_cnt = 2;
        end
      end else if (dn_seen && n_dn == 0) stall_bad++;
      if (dw_valid) begin n_dw++; t_dw = cyc; end
      if (ack_valid) begin t_ack = cyc; ack_addr_s = ack_addr; done = 1; end
      @(negedge clk);
    end
    prb_ack_valid = 0; prb_ack_last = 0; prb_ack_dirty = 0;
    wb_ack_valid = 0; dn_comp_valid = 0; dn_ready = 1;

    chk(done, "R11", "ack received", done, 1);
    chk(busy_bad == 0, "R2", "req_ready high while busy", busy_bad, 0);
    chk(req_ready == 1'b1, "R2", "idle after ack handshake", req_ready, 1);
    chk(ack_addr_s == line, "R11", "ack line address", ack_addr_s, line);
    if (!maint) begin
      chk(n_lkp + n_prb + n_wb + n_dn + n_dw == 0, "R3", "no-op handshakes",
          n_lkp + n_prb + n_wb + n_dn + n_dw, 0);
    end else begin
      chk(n_lkp == 1, "R4", "one lookup", n_lkp, 1);
      chk(n_prb == (exp_prb ? 1 : 0), "R4", "probe count", n_prb, exp_prb);
      chk(n_wb == (exp_wb ? 1 : 0), (inval ? "R5" : (dirty_idx >= 0 ? "R6" : "R5")),
          "writeback count", n_wb, exp_wb);
      chk(n_dw == (exp_dw ? 1 : 0), "R10", "directory clear count", n_dw, exp_dw);
      chk(n_dn == 1, "R9", "downstream count", n_dn, 1);
      chk(dn_kind_s == op[1:0], "R9", "downstream kind", dn_kind_s, op[1:0]);
      chk(dn_addr_s == line, "R9", "downstream address", dn_addr_s, line);
      chk(dn_exp_ack == 1'b0, "R9", "no completion ack expected", dn_exp_ack, 0);
      if (exp_wb && exp_prb)
        chk(t_wb > t_pack, "R7", "writeback after last probe answer", t_wb, t_pack + 1);
      if (cf && exp_prb)
        chk(t_dn > t_pack, "R8", "downstream after probes", t_dn, t_pack + 1);
      if (cf && exp_wb)
        chk(t_dn > t_wback, "R8", "downstream after writeback ack", t_dn, t_wback + 1);
      chk(t_ack > t_comp, "R11", "ack after completion", t_ack, t_comp + 1);
      if (exp_prb)
        chk(t_ack > t_pack, "R11", "ack after last probe answer", t_ack, t_pack + 1);
      if (dn_stall > 0)
        chk(stall_bad == 0, "R12", "downstream held stable under stall", stall_bad, 0);
    end
  endtask

  task automatic t_reset();
    chk(req_ready == 1'b1, "R1", "req_ready after reset", req_ready, 1);
    chk({lkp_valid, prb_valid, wb_valid, dn_valid, dw_valid, ack_valid} == 6'b0,
        "R1", "valids after reset",
        {lkp_valid, prb_valid, wb_valid, dn_valid, dw_valid, ack_valid}, 0);
  endtask

  task automatic t_clean_hit_clean();  run_op(3'd0, 48'h0000_1234_5678, 1, 0, 1, 2, -1, 0); endtask
  task automatic t_clean_dirty();      run_op(3'd0, 48'h0000_ABCD_00FF, 1, 1, 1, 2, -1, 0); endtask
  task automatic t_flush_miss();       run_op(3'd1, 48'h0000_0040_0013, 0, 0, 0, 0, -1, 0); endtask
  task automatic t_flush_late_dirty(); run_op(3'd1, 48'h0000_7777_1239, 1, 0, 1, 3, 1, 0); endtask
  task automatic t_inval_hit_dirty();  run_op(3'd2, 48'h0000_5555_AAAA, 1, 1, 1, 2, 0, 0); endtask
  task automatic t_inval_miss();       run_op(3'd2, 48'h0000_0001_0001, 0, 1, 1, 1, -1, 0); endtask
  task automatic t_zero_op();          run_op(3'd3, 48'h0000_2222_3333, 1, 1, 1, 1, -1, 0); endtask
  task automatic t_reserved_op();      run_op(3'd5, 48'h0000_4444_0001, 1, 0, 1, 1, -1, 0); endtask
  task automatic t_stall_no_clients(); run_op(3'd0, 48'h0000_9999_87C0, 1, 1, 0, 0, -1, 3); endtask

  initial begin
    rst_n = 0; req_valid = 0; req_op = '0; req_addr = '0;
    lkp_ready = 1; lkp_hit = 0; lkp_dirty = 0; lkp_clients = 0;
    prb_ready = 1; prb_ack_valid = 0; prb_ack_last = 0; prb_ack_dirty = 0;
    wb_ready = 1; wb_ack_valid = 0; dn_ready = 1; dn_comp_valid = 0;
    dw_ready = 1; ack_ready = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_clean_hit_clean();
    t_clean_dirty();
    t_flush_miss();
    t_flush_late_dirty();
    t_inval_hit_dirty();
    t_inval_miss();
    t_zero_op();
    t_reserved_op();
    t_stall_no_clients();
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule